// File: doc/BRIEF.md
# Synchronous Serial Master/Slave Shifter

This block moves characters of 2 to 16 bits over a three-wire synchronous serial link: a clock line, a data output and a data input. It can drive the shift clock itself from a reload divider (master), or it can follow a clock from a remote device (slave). In both cases the data is sent and received at the same time. The host sees one transmit holding buffer, one receive buffer, a few status flags and three interrupt pulses: transmit, receive and error.

Static configuration inputs set the role, the idle clock level, the clock phase, the bit order, the character length and the divider reload. A loopback switch ties the data output to the internal data input, so the block can test itself without outside wiring. In master mode a write to the transmit buffer starts a character as soon as the shifter is free. In slave mode the shifter waits for the remote clock and resends the last character if the host has not supplied a new one.

Top module: `ssc_shifter`

## Requirements
- R1: With `cfg_len_m1` = L, a character is L+1 bits for L from 1 to 15. L = 0 gives 2 bits. A received character sits right-aligned in `rx_data`, and all bits above it read as zero.
- R2: In master mode each half period of `sclk_out` lasts `cfg_reload`+1 system clocks. While the block is not busy, `sclk_out` rests at `cfg_cpol`.
- R3: With `cfg_msb_first` = 1, bit N-1 is sent first and the first received bit lands in bit N-1. With `cfg_msb_first` = 0, bit 0 comes first in both directions.
- R4: With `cfg_cpha` = 0, the first bit is on `ser_out` before the first clock edge away from `cfg_cpol`. Data is sampled on edges away from `cfg_cpol` and changes on edges back to it. With `cfg_cpha` = 1, data changes on edges away from `cfg_cpol` and is sampled on edges back to it.
- R5: With `cfg_loopback` = 1, the received character equals the transmitted one, and `ser_in` has no effect.
- R6: In master mode, a `tx_wr` while idle starts a character. When the buffer moves into the shifter, `tx_empty` rises and `irq_tx` pulses for one cycle. A write while busy stays held, with `tx_empty` low, until the current character completes.
- R7: When a character completes, `rx_data` is updated, `rx_full` is set and `irq_rx` pulses for one cycle. `rx_rd` clears `rx_full`.
- R8: If a character completes while `rx_full` is set and no `rx_rd` arrives in that cycle, `err_overrun` and `irq_err` pulse and `rx_data` is overwritten.
- R9: In slave mode, `sclk_in` passes through a two-stage synchronizer. A character starts on the first edge away from `cfg_cpol` seen while the shifter is idle.
- R10: If a slave character starts while the transmit buffer is empty, `err_underrun` and `irq_err` pulse and the previous character is sent again.
- R11: After reset the block is idle: `busy`=0, `tx_empty`=1, `rx_full`=0, and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = drive the shift clock, 0 = follow `sclk_in` |
| cfg_cpol | input | 1 | Idle level of the shift clock |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_loopback | input | 1 | Route `ser_out` to the internal data input |
| cfg_len_m1 | input | LEN_W (4) | Character length minus one |
| cfg_reload | input | DIV_W (16) | Divider reload for the master clock |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | WMAX (16) | Transmit data, right-aligned |
| tx_empty | output | 1 | Transmit buffer can take a new character |
| rx_rd | input | 1 | Read strobe; clears `rx_full` |
| rx_data | output | WMAX (16) | Last received character |
| rx_full | output | 1 | Unread character in `rx_data` |
| busy | output | 1 | A character or its closing clock edge is in progress |
| sclk_out | output | 1 | Shift clock driven in master mode |
| sclk_in | input | 1 | Shift clock from a remote master |
| ser_out | output | 1 | Serial data out |
| ser_in | input | 1 | Serial data in |
| irq_tx | output | 1 | Pulse: transmit buffer taken by the shifter |
| irq_rx | output | 1 | Pulse: character received |
| irq_err | output | 1 | Pulse: overrun or underrun |
| err_overrun | output | 1 | Pulse qualifying `irq_err` as receive overrun |
| err_underrun | output | 1 | Pulse qualifying `irq_err` as slave transmit underrun |

## Verification
The bench builds the block with its default parameters: 16-bit maximum character, 16-bit divider and a two-stage synchronizer. These defaults make the full 16-bit character and the 2-bit minimum, reached through both length codes 0 and 1, available in the same build. Small divider reloads chosen at run time keep master transfers short, so every clock polarity, phase and bit order can be covered in one run. In slave mode the bench acts as the remote master and toggles `sclk_in` slowly enough to cover the synchronizer delay. A behavioural model in the bench checks the clock line on every cycle and the serial bits on every edge.

// File: rtl/ssc_pkg.sv
// Shared types for the synchronous serial shifter.
// Assumes: all mode bits are static while a character is in flight.
package ssc_pkg;

    typedef struct packed {
        logic master;
        logic cpol;
        logic cpha;
        logic msb_first;
        logic loopback;
    } ssc_mode_t;

endpackage

// File: rtl/ssc_clkgen.sv
// Master shift-clock generator: it toggles sclk every reload+1 cycles and
// produces n_edges edges per character. It flags each edge as leading (away
// from the idle level) or trailing (back to the idle level) in the cycle
// before the line changes.
// Assumes: start is asserted only while not running.
module ssc_clkgen #(
    parameter int DIV_W  = 16,
    parameter int EDGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic [DIV_W-1:0]  reload,
    input  logic              start,
    input  logic [EDGE_W-1:0] n_edges,
    output logic              sclk,
    output logic              running,
    output logic              lead,
    output logic              trail
);
    logic [DIV_W-1:0]  cnt;
    logic [EDGE_W-1:0] left;
    logic              fire;

    // Edge strobes, decoded from the divider state.
    always_comb begin
        fire  = running && (cnt == '0);
        lead  = fire && (sclk == cpol);
        trail = fire && (sclk != cpol);
    end

    // Divider, edge budget and clock line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk    <= 1'b0;
            running <= 1'b0;
            cnt     <= '0;
            left    <= '0;
        end else if (!running) begin
            sclk <= cpol;
            if (start) begin
                running <= 1'b1;
                cnt     <= reload;
                left    <= n_edges;
            end
        end else if (cnt == '0) begin
            cnt  <= reload;
            sclk <= ~sclk;
            left <= left - 1'b1;
            if (left == EDGE_W'(1)) running <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ssc_sclk_sync.sv
// Synchronizer for an external shift clock. It presents the newest settled
// level and the level one cycle older, so the caller can detect edges.
// Assumes: the external clock half period is longer than STAGES+1 cycles.
module ssc_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level_now,
    output logic level_prev
);
    logic [STAGES:0] chain;

    // Shift chain: STAGES metastability flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], pin_in};
    end

    assign level_now  = chain[STAGES-1];
    assign level_prev = chain[STAGES];
endmodule

// File: rtl/ssc_engine.sv
// Character engine: holds the transmit and receive buffers, selects bits by
// index (so no barrel shift is needed for either bit order), launches and
// captures on the edge strobes, and raises the interrupt and error pulses.
// Assumes: lead and trail come from one clock source and never together.
module ssc_engine
    import ssc_pkg::*;
#(
    parameter int WMAX  = 16,
    parameter int CNT_W = $clog2(WMAX + 1),
    parameter int IDX_W = $clog2(WMAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ssc_mode_t        mode,
    input  logic [CNT_W-1:0] n_bits,
    input  logic             clk_running,
    input  logic             lead,
    input  logic             trail,
    input  logic             tx_wr,
    input  logic [WMAX-1:0]  tx_data,
    input  logic             rx_rd,
    input  logic             ser_in,
    output logic             ser_out,
    output logic             start_m,
    output logic             active,
    output logic             tx_full,
    output logic             rx_full,
    output logic [WMAX-1:0]  rx_buf,
    output logic             irq_tx,
    output logic             irq_rx,
    output logic             err_ovr,
    output logic             err_und
);
    logic [WMAX-1:0]  tx_buf, txw, rxw, next_word, cur_word, rxw_cur, rx_new;
    logic [CNT_W-1:0] k_tx, k_rx, cur_k_tx, cur_k_rx, out_j;
    logic             sdi, starting, eng_on, cap, lau, done;

    // Wire position of serial bit j of an n-bit character.
    function automatic logic [IDX_W-1:0] pos(input logic [CNT_W-1:0] j,
                                             input logic [CNT_W-1:0] n,
                                             input logic msb);
        logic [CNT_W-1:0] t;
        t = msb ? (n - j - 1'b1) : j;
        return t[IDX_W-1:0];
    endfunction

    // Next-state decode for a start, a launch and a capture.
    always_comb begin
        next_word = tx_full ? tx_buf : txw;
        out_j     = (k_tx == '0) ? '0 : k_tx - 1'b1;
        ser_out   = active ? txw[pos(out_j, n_bits, mode.msb_first)]
                           : next_word[pos('0, n_bits, mode.msb_first)];
        sdi       = mode.loopback ? ser_out : ser_in;
        start_m   = mode.master && tx_full && !active && !clk_running;
        starting  = !active && (start_m || (!mode.master && lead));
        eng_on    = active || starting;
        cur_word  = starting ? next_word : txw;
        cur_k_tx  = starting ? (mode.cpha ? '0 : CNT_W'(1)) : k_tx;
        cur_k_rx  = starting ? '0 : k_rx;
        rxw_cur   = starting ? '0 : rxw;
        cap       = eng_on && (mode.cpha ? trail : lead);
        lau       = eng_on && (mode.cpha ? lead : trail) && (cur_k_tx < n_bits);
        rx_new    = rxw_cur;
        rx_new[pos(cur_k_rx, n_bits, mode.msb_first)] = sdi;
        done      = cap && (cur_k_rx == n_bits - 1'b1);
    end

    // Buffers, bit counters and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            txw     <= '0;
            rxw     <= '0;
            rx_buf  <= '0;
            k_tx    <= '0;
            k_rx    <= '0;
            active  <= 1'b0;
            tx_full <= 1'b0;
            rx_full <= 1'b0;
            irq_tx  <= 1'b0;
            irq_rx  <= 1'b0;
            err_ovr <= 1'b0;
            err_und <= 1'b0;
        end else begin
            irq_tx  <= 1'b0;
            irq_rx  <= 1'b0;
            err_ovr <= 1'b0;
            err_und <= 1'b0;
            if (rx_rd) rx_full <= 1'b0;
            if (starting) begin
                txw <= cur_word;
                if (tx_full) begin
                    tx_full <= 1'b0;
                    irq_tx  <= 1'b1;
                end else begin
                    err_und <= 1'b1;
                end
            end
            if (eng_on) begin
                active <= !done;
                k_tx   <= cur_k_tx + CNT_W'(lau);
                k_rx   <= cap ? cur_k_rx + 1'b1 : cur_k_rx;
                rxw    <= cap ? rx_new : rxw_cur;
            end
            if (done) begin
                rx_buf  <= rx_new;
                rx_full <= 1'b1;
                irq_rx  <= 1'b1;
                if (rx_full && !rx_rd) err_ovr <= 1'b1;
            end
            if (tx_wr) begin
                tx_buf  <= tx_data;
                tx_full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssc_shifter.sv
// Top of the synchronous serial shifter. It takes the edge strobes from the
// internal divider (master) or the synchronized external clock (slave),
// feeds them to the character engine and merges the error pulses.
// Assumes: configuration inputs change only while busy is low.
module ssc_shifter
    import ssc_pkg::*;
#(
    parameter int WMAX        = 16,
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int LEN_W       = $clog2(WMAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_master,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_msb_first,
    input  logic             cfg_loopback,
    input  logic [LEN_W-1:0] cfg_len_m1,
    input  logic [DIV_W-1:0] cfg_reload,
    input  logic             tx_wr,
    input  logic [WMAX-1:0]  tx_data,
    output logic             tx_empty,
    input  logic             rx_rd,
    output logic [WMAX-1:0]  rx_data,
    output logic             rx_full,
    output logic             busy,
    output logic             sclk_out,
    input  logic             sclk_in,
    output logic             ser_out,
    input  logic             ser_in,
    output logic             irq_tx,
    output logic             irq_rx,
    output logic             irq_err,
    output logic             err_overrun,
    output logic             err_underrun
);
    localparam int CNT_W  = $clog2(WMAX + 1);
    localparam int EDGE_W = CNT_W + 1;

    ssc_mode_t        mode;
    logic [CNT_W-1:0] n_bits;
    logic             m_lead, m_trail, m_running, start_m;
    logic             s_now, s_prev, s_edge;
    logic             lead, trail, active, tx_full;

    // Mode bundle and effective character length (code 0 maps to 2 bits).
    always_comb begin
        mode   = '{master: cfg_master, cpol: cfg_cpol, cpha: cfg_cpha,
                   msb_first: cfg_msb_first, loopback: cfg_loopback};
        n_bits = (cfg_len_m1 == '0) ? CNT_W'(2) : CNT_W'(cfg_len_m1) + 1'b1;
    end

    ssc_clkgen #(.DIV_W(DIV_W), .EDGE_W(EDGE_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpol    (cfg_cpol),
        .reload  (cfg_reload),
        .start   (start_m),
        .n_edges ({n_bits, 1'b0}),
        .sclk    (sclk_out),
        .running (m_running),
        .lead    (m_lead),
        .trail   (m_trail)
    );

    ssc_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (sclk_in),
        .level_now  (s_now),
        .level_prev (s_prev)
    );

    // Edge source select: internal divider or external clock.
    always_comb begin
        s_edge = s_now ^ s_prev;
        lead   = cfg_master ? m_lead  : (s_edge && (s_prev == cfg_cpol));
        trail  = cfg_master ? m_trail : (s_edge && (s_prev != cfg_cpol));
    end

    ssc_engine #(.WMAX(WMAX), .CNT_W(CNT_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .n_bits      (n_bits),
        .clk_running (m_running),
        .lead        (lead),
        .trail       (trail),
        .tx_wr       (tx_wr),
        .tx_data     (tx_data),
        .rx_rd       (rx_rd),
        .ser_in      (ser_in),
        .ser_out     (ser_out),
        .start_m     (start_m),
        .active      (active),
        .tx_full     (tx_full),
        .rx_full     (rx_full),
        .rx_buf      (rx_data),
        .irq_tx      (irq_tx),
        .irq_rx      (irq_rx),
        .err_ovr     (err_overrun),
        .err_und     (err_underrun)
    );

    assign tx_empty = !tx_full;
    assign busy     = active | m_running;
    assign irq_err  = err_overrun | err_underrun;
endmodule

// File: rtl/ssc_shifter_chk.sv
// Protocol checker for ssc_shifter, attached through bind.
// Assumes: the configuration is held steady between transfers.
module ssc_shifter_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_master,
    input logic cfg_cpol,
    input logic tx_wr,
    input logic tx_empty,
    input logic rx_full,
    input logic busy,
    input logic sclk_out,
    input logic irq_tx,
    input logic irq_rx,
    input logic err_overrun,
    input logic err_underrun
);
    logic armed;

    // Marks that one clock has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_idle_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && cfg_master && !busy && $stable(cfg_cpol) |-> sclk_out == cfg_cpol);

    p_tx_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx && !$past(tx_wr) |-> tx_empty);

    p_rx_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> rx_full);

    p_overrun_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> irq_rx);

    p_underrun_slave_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_underrun |-> !$past(cfg_master));
endmodule

bind ssc_shifter ssc_shifter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_master   (cfg_master),
    .cfg_cpol     (cfg_cpol),
    .tx_wr        (tx_wr),
    .tx_empty     (tx_empty),
    .rx_full      (rx_full),
    .busy         (busy),
    .sclk_out     (sclk_out),
    .irq_tx       (irq_tx),
    .irq_rx       (irq_rx),
    .err_overrun  (err_overrun),
    .err_underrun (err_underrun)
);

// File: tb/tb_ssc_shifter.sv
// Bench for ssc_shifter. A behavioural peer model plays the remote slave in
// master mode and the remote master in slave mode. It checks the clock line
// on every cycle and the serial bits on every edge.
module tb_ssc_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic        cfg_msb_first = 1'b0, cfg_loopback = 1'b0;
    logic [3:0]  cfg_len_m1 = 4'd7;
    logic [15:0] cfg_reload = 16'd1;
    logic        tx_wr = 1'b0, rx_rd = 1'b0, sclk_in = 1'b0, ser_in = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_empty, rx_full, busy, sclk_out, ser_out;
    logic        irq_tx, irq_rx, irq_err, err_overrun, err_underrun;
    logic [15:0] rx_data;

    int checks = 0, errors = 0;
    int n_tx = 0, n_rx = 0, n_err = 0, n_ovr = 0, n_und = 0;
    bit finished = 0;
    logic prev_cpol = 1'b0;

    ssc_shifter dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Event counters and the per-cycle check of the idle clock level (R2).
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_tx) n_tx++;
            if (irq_rx) n_rx++;
            if (irq_err) n_err++;
            if (err_overrun) n_ovr++;
            if (err_underrun) n_und++;
            if (cfg_master && !busy && prev_cpol == cfg_cpol && sclk_out !== cfg_cpol)
                chk(0, "R2 idle clock level", sclk_out, cfg_cpol);
        end
        prev_cpol <= cfg_cpol;
    end

    function automatic int nb_of();
        return (cfg_len_m1 == 0) ? 2 : int'(cfg_len_m1) + 1;
    endfunction

    function automatic int pos(input int j, input int n);
        return cfg_msb_first ? n - 1 - j : j;
    endfunction

    function automatic logic [15:0] mask(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    endfunction

    task automatic read_rx(input string tag);
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
        chk(rx_full == 1'b0, tag, rx_full, 0);
    endtask

    // Bench as remote slave: follows sclk_out, captures ser_out and drives ser_in.
    task automatic m_xfer(input logic [15:0] dw, input logic [15:0] pw, input string tag);
        int n, nb, nl, since, edges, tx0, rx0;
        logic [15:0] got;
        logic prev_s, prev_o, s, cap;
        n = nb_of(); nb = 0; nl = 0; since = 0; edges = 0; got = '0;
        tx0 = n_tx; rx0 = n_rx;
        @(negedge clk);
        ser_in = pw[pos(0, n)];
        tx_data = dw; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        prev_s = sclk_out; prev_o = ser_out;
        while (nb < n) begin
            @(negedge clk);
            s = sclk_out; since++;
            if (s !== prev_s) begin
                if (edges > 0) chk(since == int'(cfg_reload) + 1, "R2 half period", since, int'(cfg_reload) + 1);
                edges++; since = 0;
                cap = (prev_s == cfg_cpol) ^ cfg_cpha;
                if (cap) begin
                    got[pos(nb, n)] = prev_o; nb++;
                end else if (cfg_cpha) begin
                    ser_in = pw[pos(nl, n)]; nl++;
                end else begin
                    nl++;
                    if (nl < n) ser_in = pw[pos(nl, n)];
                end
            end
            prev_s = s; prev_o = ser_out;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(got == (dw & mask(n)), {tag, " sent bits R3 R4"}, got, dw & mask(n));
        chk(rx_data == (pw & mask(n)), {tag, " received R1 R7"}, rx_data, pw & mask(n));
        chk(n_tx == tx0 + 1 && tx_empty, {tag, " R6 tx irq"}, n_tx - tx0, 1);
        chk(n_rx == rx0 + 1 && rx_full, {tag, " R7 rx irq"}, n_rx - rx0, 1);
        read_rx({tag, " R7 read clears"});
    endtask

    // Bench as remote master: toggles sclk_in with a slow half period.
    task automatic s_xfer(input logic [15:0] expw, input logic [15:0] pw, input string tag);
        int n, rx0;
        logic [15:0] got;
        n = nb_of(); got = '0; rx0 = n_rx;
        if (!cfg_cpha) ser_in = pw[pos(0, n)];
        repeat (4) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            if (!cfg_cpha) got[pos(b, n)] = ser_out;
            sclk_in = ~cfg_cpol;
            if (cfg_cpha) ser_in = pw[pos(b, n)];
            repeat (8) @(negedge clk);
            if (cfg_cpha) got[pos(b, n)] = ser_out;
            sclk_in = cfg_cpol;
            if (!cfg_cpha && b + 1 < n) ser_in = pw[pos(b + 1, n)];
            repeat (8) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(got == (expw & mask(n)), {tag, " R9 slave sent"}, got, expw & mask(n));
        chk(rx_data == (pw & mask(n)), {tag, " R9 slave received"}, rx_data, pw & mask(n));
        chk(n_rx == rx0 + 1 && !busy, {tag, " R9 one character"}, n_rx - rx0, 1);
        read_rx({tag, " R7 read clears"});
    endtask

    initial begin
        int e0, o0, u0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: idle after reset
        chk(!busy && tx_empty && !rx_full, "R11 reset status", {busy, tx_empty, rx_full}, 3'b010);
        chk(!irq_tx && !irq_rx && !irq_err, "R11 reset irqs", {irq_tx, irq_rx, irq_err}, 0);
        chk(sclk_out == 1'b0, "R11 R2 reset clock", sclk_out, 0);

        // Master, idle low, phase 0, LSB first, 8 bits
        m_xfer(16'h00A5, 16'hFF3C, "M1");
        // Master, idle high, phase 1, MSB first, 16 bits
        cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_msb_first = 1'b1; cfg_len_m1 = 4'd15; cfg_reload = 16'd3;
        repeat (2) @(negedge clk);
        m_xfer(16'hBEEF, 16'h1234, "M2");
        // Master, 2-bit characters from both short length codes (R1)
        cfg_cpol = 1'b0; cfg_len_m1 = 4'd0; cfg_reload = 16'd2;
        repeat (2) @(negedge clk);
        m_xfer(16'hFFFE, 16'hFFF1, "M3 R1 code0");
        cfg_len_m1 = 4'd1; cfg_cpha = 1'b0; cfg_msb_first = 1'b0;
        m_xfer(16'h0001, 16'h0002, "M4 R1 code1");
        // Master, idle high, phase 0, 5 bits, fastest divider
        cfg_cpol = 1'b1; cfg_len_m1 = 4'd4; cfg_reload = 16'd0;
        repeat (2) @(negedge clk);
        m_xfer(16'h0013, 16'h000C, "M5");

        // Loopback with a held write and an overrun (R5, R6, R8)
        cfg_cpol = 1'b0; cfg_loopback = 1'b1; cfg_len_m1 = 4'd11; cfg_reload = 16'd1;
        ser_in = 1'b1;
        repeat (2) @(negedge clk);
        e0 = n_err; o0 = n_ovr;
        tx_data = 16'h0ABC; tx_wr = 1'b1; @(negedge clk);
        tx_data = 16'h0123; @(negedge clk); tx_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy && !tx_empty, "R6 write held while busy", {busy, tx_empty}, 2'b10);
        repeat (6) @(negedge clk);
        while (busy || !tx_empty) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(rx_data == 16'h0123, "R5 loopback ignores ser_in", rx_data, 16'h0123);
        chk(n_ovr == o0 + 1 && n_err == e0 + 1, "R8 overrun pulse", n_ovr - o0, 1);
        read_rx("R8 read after overrun");
        cfg_loopback = 1'b0;

        // Slave, idle low, phase 1, LSB first, 8 bits
        cfg_master = 1'b0; cfg_cpha = 1'b1; cfg_msb_first = 1'b0; cfg_len_m1 = 4'd7;
        sclk_in = 1'b0;
        @(negedge clk); tx_data = 16'h005A; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
        u0 = n_und;
        s_xfer(16'h005A, 16'h00C3, "S1");
        chk(n_und == u0 && tx_empty, "R9 no underrun with data", n_und - u0, 0);
        // Slave start without a new write: underrun, old character resent (R10)
        e0 = n_err;
        s_xfer(16'h005A, 16'h0071, "S2 R10");
        chk(n_und == u0 + 1 && n_err == e0 + 1, "R10 underrun pulse", n_und - u0, 1);
        // Slave, idle high, phase 0, MSB first, 10 bits
        cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_msb_first = 1'b1; cfg_len_m1 = 4'd9;
        sclk_in = 1'b1;
        repeat (6) @(negedge clk);
        tx_data = 16'h02AB; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
        s_xfer(16'h02AB, 16'hF155, "S3 R4");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule